// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Receiver

This block sits behind a line-state recovery stage. Each cycle that `bit_stb` is high, `line_st` holds the bus state for one bit time. While idle, the receiver hunts for the synchronisation pattern. Once it locks, it NRZI-decodes the levels that follow, drops the bit that is stuffed after every run of six decoded ones, and packs the remaining bits LSB first into bytes. Each finished byte appears for one cycle with `byte_vld`.

A packet closes normally on the two-SE0-then-J trailer. In that case `pkt_end` pulses, and `frame_err` pulses with it if a byte was only partly filled. Some conditions drop the packet and send the receiver back to the hunt:

- a run of seven equal levels, which raises `stuff_err`;
- a lone SE0;
- an SE1;
- a broken trailer.

The last three raise `frame_err`. CRC and PID handling belong to later stages.

Top module: `usb_pkt_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `byte_vld`, `pkt_end`, `stuff_err`, `frame_err` and `pkt_active` are 0.
- R2: `line_st` encodes the two wires, with bit 1 the positive line: J = 2'b10, K = 2'b01, SE0 = 2'b00, SE1 = 2'b11. Reception starts only after the strobed states K J K J K J K K. `pkt_active` becomes 1 one cycle after the strobe that carries the final K.
- R3: A data level equal to the previous strobed level decodes as 1, and a changed level decodes as 0. The first data level is compared against the final K of the sync pattern.
- R4: Decoded bits fill a byte LSB first. One cycle after the strobe of each eighth kept bit, `byte_vld` pulses for one cycle with that byte on `byte_data`.
- R5: The level that follows six consecutive decoded ones is discarded when it is a transition. It adds no bit and clears the run.
- R6: If the level after six consecutive ones repeats the previous level, `stuff_err` pulses one cycle later, `pkt_active` drops and no `pkt_end` follows.
- R7: SE0, SE0, J during reception gives a one-cycle `pkt_end` pulse one cycle after the J strobe, with `pkt_active` going to 0.
- R8: If the trailer arrives while a byte holds 1 to 7 bits, `frame_err` pulses in the same cycle as `pkt_end`. With no partial byte, `frame_err` stays 0.
- R9: In each of the following cases, `frame_err` pulses without `pkt_end` and reception is dropped: a single SE0 followed by J or K, SE1 during data, or two SE0s followed by anything other than J.
- R10: An SE0 that falls inside the eight-state sync window prevents lock. A later complete sync pattern is still recognised.
- R11: Cycles without `bit_stb` change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | `line_st` holds a new bit-time state |
| line_st | input | 2 | Line state: J 2'b10, K 2'b01, SE0 2'b00, SE1 2'b11 |
| byte_data | output | BYTE_W | Assembled byte, valid with `byte_vld` |
| byte_vld | output | 1 | One-cycle pulse per finished byte |
| pkt_active | output | 1 | Sync locked, packet in progress |
| pkt_end | output | 1 | One-cycle pulse on a valid trailer |
| stuff_err | output | 1 | One-cycle pulse on a missing stuff transition |
| frame_err | output | 1 | One-cycle pulse on a partial byte at the end or a malformed end |

## Verification
The assertions assume that `bit_stb` is low while reset is held and that `line_st` carries one of the four defined codes whenever it is strobed. They relate each output pulse to the strobe and line state of the previous cycle. The bench changes inputs only on the falling clock edge and holds `bit_stb` low during reset. It builds every line sequence from a bit-level transmitter model, using NRZI from the sync K and stuffing after six ones. Strobe gaps of zero to two cycles put idle cycles between bit times.

// File: rtl/usb_pkt_rx.sv
module usb_pkt_rx #(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [1:0]        line_st,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              pkt_active,
  output logic              pkt_end,
  output logic              stuff_err,
  output logic              frame_err
);

  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int HIST_W = 16;
  localparam logic [CNT_W-1:0] BLAST   = CNT_W'(BYTE_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);
  localparam logic [1:0] LS_SE0 = 2'b00, LS_K = 2'b01, LS_J = 2'b10, LS_SE1 = 2'b11;
  localparam logic [HIST_W-1:0] SYNC_PAT = {LS_K, LS_J, LS_K, LS_J, LS_K, LS_J, LS_K, LS_K};

  typedef enum logic [1:0] {S_HUNT, S_DATA, S_EOP1, S_EOP2} st_t;

  st_t               st;
  logic [HIST_W-1:0] hist;
  logic [1:0]        ref_lv;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bcnt;
  logic [RUN_W-1:0]  ones;

  wire [HIST_W-1:0] hist_nx = {hist[HIST_W-3:0], line_st};
  wire              dbit    = (line_st == ref_lv);
  wire [BYTE_W-1:0] sh_nx   = {dbit, shreg[BYTE_W-1:1]};

  assign pkt_active = (st != S_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HUNT;
      hist      <= '0;
      ref_lv    <= LS_K;
      shreg     <= '0;
      bcnt      <= '0;
      ones      <= '0;
      byte_data <= '0;
      byte_vld  <= 1'b0;
      pkt_end   <= 1'b0;
      stuff_err <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      pkt_end   <= 1'b0;
      stuff_err <= 1'b0;
      frame_err <= 1'b0;
      if (bit_stb) begin
        case (st)
          S_HUNT: begin
            hist <= hist_nx;
            if (hist_nx == SYNC_PAT) begin
              st     <= S_DATA;
              ref_lv <= LS_K;
              ones   <= '0;
              bcnt   <= '0;
            end
          end
          S_DATA: begin
            if (line_st == LS_SE0) begin
              st <= S_EOP1;
            end else if (line_st == LS_SE1) begin
              frame_err <= 1'b1;
              st        <= S_HUNT;
              hist      <= '0;
            end else begin
              ref_lv <= line_st;
              if (ones == RUN_MAX) begin
                if (dbit) begin
                  stuff_err <= 1'b1;
                  st        <= S_HUNT;
                  hist      <= '0;
                end else begin
                  ones <= '0;
                end
              end else begin
                shreg <= sh_nx;
                ones  <= dbit ? ones + RUN_W'(1) : '0;
                if (bcnt == BLAST) begin
                  byte_vld  <= 1'b1;
                  byte_data <= sh_nx;
                  bcnt      <= '0;
                end else begin
                  bcnt <= bcnt + CNT_W'(1);
                end
              end
            end
          end
          S_EOP1: begin
            if (line_st == LS_SE0) begin
              st <= S_EOP2;
            end else begin
              frame_err <= 1'b1;
              st        <= S_HUNT;
              hist      <= '0;
            end
          end
          default: begin
            st   <= S_HUNT;
            hist <= '0;
            if (line_st == LS_J) begin
              pkt_end   <= 1'b1;
              frame_err <= (bcnt != '0);
            end else begin
              frame_err <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  a_r2_lock_on_k: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_active) |-> ($past(bit_stb) && $past(line_st) == LS_K));

  a_r4_byte_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(bit_stb) && $past(pkt_active)));

  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX);

  a_r6_stuff_drops: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (!pkt_active && $past(pkt_active) && $past(line_st == ref_lv)));

  a_r7_end_on_j: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ($past(bit_stb) && $past(line_st) == LS_J && !pkt_active));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> (!byte_vld && !pkt_end && !stuff_err && !frame_err && $stable(pkt_active)));

endmodule

// File: tb/usb_pkt_rx_test.sv
module usb_pkt_rx_test;
  localparam int LS0 = 0, LK = 1, LJ = 2, LS1 = 3;
  localparam int EV_NONE = 0, EV_BYTE = 1, EV_END = 2, EV_ENDF = 3, EV_STUFF = 4, EV_FERR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic [1:0] line_st = 2'(LJ);
  logic [7:0] byte_data;
  logic byte_vld, pkt_active, pkt_end, stuff_err, frame_err;

  usb_pkt_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_st(line_st),
    .byte_data(byte_data), .byte_vld(byte_vld), .pkt_active(pkt_active),
    .pkt_end(pkt_end), .stuff_err(stuff_err), .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int q_ln[$], q_ev[$], q_dt[$], q_ac[$], q_gap[$];
  int lvl = LK, ones = 0;
  int exp_ev = EV_NONE, exp_dt = 0, exp_ac = 0, gap_cnt = 0;
  bit run = 1'b0, done = 1'b0;
  int cyc = 0;

  task automatic push(int ln, int ev, int dt, int ac, int gap);
    q_ln.push_back(ln); q_ev.push_back(ev); q_dt.push_back(dt);
    q_ac.push_back(ac); q_gap.push_back(gap);
  endtask

  task automatic sync_seq(int gap);
    push(LK, EV_NONE, 0, 0, gap); push(LJ, EV_NONE, 0, 0, gap);
    push(LK, EV_NONE, 0, 0, gap); push(LJ, EV_NONE, 0, 0, gap);
    push(LK, EV_NONE, 0, 0, gap); push(LJ, EV_NONE, 0, 0, gap);
    push(LK, EV_NONE, 0, 0, gap); push(LK, EV_NONE, 0, 1, gap);
    lvl = LK; ones = 0;
  endtask

  task automatic send_bit(int b, int gap, int ev, int dt);
    if (b == 0) lvl = (lvl == LK) ? LJ : LK;
    push(lvl, ev, dt, 1, gap);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin
      lvl = (lvl == LK) ? LJ : LK;
      push(lvl, EV_NONE, 0, 1, gap);
      ones = 0;
    end
  endtask

  task automatic send_byte(int v, int gap);
    for (int i = 0; i < 8; i++)
      send_bit((v >> i) & 1, gap, (i == 7) ? EV_BYTE : EV_NONE, v);
  endtask

  task automatic eop(bit partial, int gap);
    push(LS0, EV_NONE, 0, 1, gap); push(LS0, EV_NONE, 0, 1, gap);
    push(LJ, partial ? EV_ENDF : EV_END, 0, 0, gap);
  endtask

  task automatic idle(int n, int gap);
    for (int i = 0; i < n; i++) push(LJ, EV_NONE, 0, 0, gap);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic string tag(int ev);
    case (ev)
      EV_BYTE:  return "R4";
      EV_END:   return "R7";
      EV_ENDF:  return "R8";
      EV_STUFF: return "R6";
      EV_FERR:  return "R9";
      default:  return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (run) begin
      chk(byte_vld == (exp_ev == EV_BYTE), tag(exp_ev), "byte_vld", int'(byte_vld), int'(exp_ev == EV_BYTE));
      if (exp_ev == EV_BYTE)
        chk(byte_data == 8'(exp_dt), "R4", "byte_data", int'(byte_data), exp_dt);
      chk(pkt_end == (exp_ev == EV_END || exp_ev == EV_ENDF), tag(exp_ev), "pkt_end",
          int'(pkt_end), int'(exp_ev == EV_END || exp_ev == EV_ENDF));
      chk(stuff_err == (exp_ev == EV_STUFF), tag(exp_ev), "stuff_err", int'(stuff_err), int'(exp_ev == EV_STUFF));
      chk(frame_err == (exp_ev == EV_ENDF || exp_ev == EV_FERR), tag(exp_ev), "frame_err",
          int'(frame_err), int'(exp_ev == EV_ENDF || exp_ev == EV_FERR));
      chk(pkt_active == exp_ac[0], "R2", "pkt_active", int'(pkt_active), exp_ac);
      exp_ev = EV_NONE;
      if (gap_cnt > 0) begin
        gap_cnt--;
        bit_stb <= 1'b0;
        line_st <= 2'(LS1);
      end else if (q_ln.size() > 0) begin
        bit_stb <= 1'b1;
        line_st <= 2'(q_ln.pop_front());
        exp_ev  = q_ev.pop_front();
        exp_dt  = q_dt.pop_front();
        exp_ac  = q_ac.pop_front();
        gap_cnt = q_gap.pop_front();
      end else begin
        bit_stb <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2 R3 R4 R7: plain packet, strobe every cycle
    idle(3, 0); sync_seq(0); send_byte(8'hA5, 0); send_byte(8'h3C, 0); eop(0, 0); idle(3, 0);
    // R5: long runs of ones force stuffed bits, gaps between strobes
    sync_seq(2); send_byte(8'hFF, 2); send_byte(8'hFF, 2); send_byte(8'h7E, 2); send_byte(8'h80, 2);
    eop(0, 2); idle(2, 1);
    // R8: partial byte at end
    sync_seq(1); send_byte(8'h3F, 1); send_bit(1, 1, EV_NONE, 0); send_bit(0, 1, EV_NONE, 0);
    send_bit(1, 1, EV_NONE, 0); eop(1, 1); idle(2, 0);
    // R6: missing stuff transition
    sync_seq(0); send_byte(8'hA5, 0); send_bit(0, 0, EV_NONE, 0);
    for (int i = 0; i < 6; i++) push(lvl, EV_NONE, 0, 1, 0);
    push(lvl, EV_STUFF, 0, 0, 0); idle(3, 0);
    // R9: lone SE0
    sync_seq(0); send_byte(8'h12, 0); push(LS0, EV_NONE, 0, 1, 0); push(LJ, EV_FERR, 0, 0, 0); idle(2, 0);
    // R9: SE1 inside data
    sync_seq(1); send_byte(8'h55, 1); push(LS1, EV_FERR, 0, 0, 1); idle(2, 0);
    // R9: two SE0 then K
    sync_seq(0); send_byte(8'h0F, 0); push(LS0, EV_NONE, 0, 1, 0); push(LS0, EV_NONE, 0, 1, 0);
    push(LK, EV_FERR, 0, 0, 0); idle(3, 0);
    // R10: SE0 inside sync window, then a clean packet and an empty packet
    push(LK, EV_NONE, 0, 0, 0); push(LJ, EV_NONE, 0, 0, 0); push(LK, EV_NONE, 0, 0, 0);
    push(LJ, EV_NONE, 0, 0, 0); push(LS0, EV_NONE, 0, 0, 0); push(LJ, EV_NONE, 0, 0, 0);
    push(LK, EV_NONE, 0, 0, 0); push(LK, EV_NONE, 0, 0, 0);
    push(LJ, EV_NONE, 0, 0, 0); push(LK, EV_NONE, 0, 0, 0); idle(3, 0);
    sync_seq(0); send_byte(8'hC3, 0); eop(0, 0); idle(2, 0);
    sync_seq(2); eop(0, 2); idle(2, 0);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!byte_vld && !pkt_end && !stuff_err && !frame_err, "R1", "pulses in reset",
        int'(byte_vld | pkt_end | stuff_err | frame_err), 0);
    chk(!pkt_active, "R1", "pkt_active in reset", int'(pkt_active), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_active && !byte_vld, "R1", "after reset", int'(pkt_active | byte_vld), 0);
    run = 1'b1;
    while (q_ln.size() > 0 || gap_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule